// File: doc/BRIEF.md
# Serial Receiver with Per-Character Error Tags

This block is the receive half of an asynchronous serial port. It samples the incoming line sixteen times per bit, using a tick that a programmable 12-bit divisor derives from the core clock. It recovers characters of five to eight data bits, checks optional odd or even parity and the stop bit, and stores each character in a small queue.

Every entry carries three error tags: framing, parity and overrun. A host that drains the queue gets each character together with the errors that belong to it, in one 11-bit read word. There is no separate status register. The host watches an empty flag, or the receive interrupt, and pops words until the queue is empty.

Line format, divisor and queue mode come in as static configuration inputs. They are changed only while the line is idle and the queue is empty. Break conditions show up only as framing errors.

Top module: `serial_rx_tagq`

## Requirements
- R1: The oversampling tick fires once every `cfg_div_i + 1` clocks and one bit lasts 16 ticks, so the bit rate is clk / (16 × (divisor + 1)); frames sent at that rate decode correctly for any divisor.
- R2: `cfg_len_i` selects the character length: 0 = 5, 1 = 6, 2 = 7, 3 = 8 data bits, sent least significant bit first. Bits of the read word above the character length read as zero.
- R3: With `cfg_par_en_i` = 0 no parity bit is expected and bit 9 of the read word is always 0. With it set, `cfg_par_even_i` = 1 selects even parity and 0 selects odd parity. A parity bit that does not match sets bit 9 of that character's word.
- R4: A first stop bit sampled low sets bit 8 (framing error) of that character's word. With `cfg_two_stop_i` = 1 the second stop bit is not checked. After a stop bit sampled low, a new start bit is accepted only after the line has been seen high.
- R5: With `cfg_fifo_en_i` = 1 the queue holds 16 characters, returned in arrival order. With it clear, the queue holds one character.
- R6: A character that arrives while the queue is full is discarded. Bit 10 (overrun) is set on the next character that is stored, and on that character only.
- R7: `rx_empty_o` is 1 exactly when the queue holds nothing, and `rx_irq_o` is its inverse. A pop request while the queue is empty has no effect.
- R8: A falling edge is checked again 8 ticks later. If the line is high by then, the edge is dropped as a false start and nothing is stored.
- R9: The read word carries the character in bits 7:0, framing in bit 8, parity in bit 9 and overrun in bit 10. It reads as all zeros while the queue is empty. A one-cycle `rd_pop_i` pulse removes the head word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_div_i | input | 12 | Divisor: tick period is divisor + 1 clocks |
| cfg_len_i | input | 2 | Character length code (5 + code bits) |
| cfg_par_en_i | input | 1 | Parity bit present |
| cfg_par_even_i | input | 1 | 1 = even parity, 0 = odd parity |
| cfg_two_stop_i | input | 1 | Two stop bits on the line |
| cfg_fifo_en_i | input | 1 | 1 = 16-entry queue, 0 = single holding slot |
| rxd_i | input | 1 | Serial input line, idle high |
| rd_pop_i | input | 1 | Pop the head word |
| rd_word_o | output | 11 | Head word: {overrun, parity, framing, character} |
| rx_empty_o | output | 1 | Queue holds no character |
| rx_irq_o | output | 1 | Receive interrupt, high while the queue is not empty |

## Verification
A wrong oversample or bit counter corrupts the very next character at the read port. Bits come out shifted, or the parity and framing tags are wrong, as soon as that frame is popped. Queue pointer or count errors appear as characters out of order, lost, or repeated, or as an empty flag that disagrees with the number of characters written, and these show within one fill-and-drain sequence. A stale or sticky overrun latch marks the wrong word, so the bench sends a defined run of characters past the full point and checks bit 10 on the first word stored after the loss and on the word after it.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;

  // Deframer phases
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP,
    ST_STOP2
  } rx_state_e;

  // Word stored per character; field order is the host-visible layout
  typedef struct packed {
    logic       ovr;
    logic       perr;
    logic       ferr;
    logic [7:0] data;
  } rx_word_t;

  localparam int unsigned OS_LAST = 15;  // last oversample index of a bit
  localparam int unsigned OS_MID  = 7;   // start bit re-check point

  function automatic logic [3:0] char_bits(input logic [1:0] code);
    return 4'd5 + {2'b00, code};
  endfunction

endpackage

// File: rtl/serial_rx_tick.sv
module serial_rx_tick #(
  parameter int unsigned DIV_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);

  logic [DIV_W-1:0] cnt_q, cnt_d;

  always_comb begin
    tick_o = (cnt_q >= div_i);
    cnt_d  = tick_o ? '0 : cnt_q + DIV_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

endmodule

// File: rtl/serial_rx_deframe.sv
module serial_rx_deframe
  import serial_rx_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       rxd_i,
  input  logic [1:0] len_i,
  input  logic       par_en_i,
  input  logic       par_even_i,
  input  logic       two_stop_i,
  output logic       push_o,
  output logic [9:0] push_word_o   // {perr, ferr, data}
);

  rx_state_e  state_q, state_d;
  logic [3:0] os_q, os_d;
  logic [2:0] nbit_q, nbit_d;
  logic [7:0] sh_q, sh_d;
  logic       perr_q, perr_d;
  logic       idle_hi_q, idle_hi_d;

  logic [3:0] nbits;
  logic [7:0] data_al;
  logic       par_exp;
  logic       bit_end;
  logic       ferr;

  always_comb begin
    nbits   = char_bits(len_i);
    data_al = sh_q >> (4'd8 - nbits);
    par_exp = (^data_al) ^ ~par_even_i;
    bit_end = tick_i && (os_q == 4'(OS_LAST));
  end

  always_comb begin
    state_d   = state_q;
    os_d      = os_q;
    nbit_d    = nbit_q;
    sh_d      = sh_q;
    perr_d    = perr_q;
    idle_hi_d = idle_hi_q;
    push_o    = 1'b0;
    ferr      = 1'b0;
    if (tick_i && state_q != ST_IDLE) os_d = os_q + 4'd1;
    unique case (state_q)
      ST_IDLE: begin
        if (tick_i) begin
          if (rxd_i) begin
            idle_hi_d = 1'b1;
          end else if (idle_hi_q) begin
            state_d = ST_START;
            os_d    = '0;
          end
        end
      end
      ST_START: begin
        if (tick_i && os_q == 4'(OS_MID)) begin
          os_d = '0;
          if (rxd_i) begin
            state_d   = ST_IDLE;
            idle_hi_d = 1'b1;
          end else begin
            state_d = ST_DATA;
            nbit_d  = '0;
            perr_d  = 1'b0;
          end
        end
      end
      ST_DATA: begin
        if (bit_end) begin
          sh_d = {rxd_i, sh_q[7:1]};
          if ({1'b0, nbit_q} == nbits - 4'd1) state_d = par_en_i ? ST_PAR : ST_STOP;
          else                                nbit_d  = nbit_q + 3'd1;
        end
      end
      ST_PAR: begin
        if (bit_end) begin
          perr_d  = (rxd_i != par_exp);
          state_d = ST_STOP;
        end
      end
      ST_STOP: begin
        if (bit_end) begin
          push_o = 1'b1;
          ferr   = ~rxd_i;
          if (two_stop_i) begin
            state_d = ST_STOP2;
          end else begin
            state_d   = ST_IDLE;
            idle_hi_d = rxd_i;
          end
        end
      end
      ST_STOP2: begin
        if (bit_end) begin
          state_d   = ST_IDLE;
          idle_hi_d = rxd_i;
        end
      end
      default: state_d = ST_IDLE;
    endcase
    push_word_o = {perr_q, ferr, data_al};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      os_q      <= '0;
      nbit_q    <= '0;
      sh_q      <= '0;
      perr_q    <= 1'b0;
      idle_hi_q <= 1'b0;
    end else begin
      state_q   <= state_d;
      os_q      <= os_d;
      nbit_q    <= nbit_d;
      sh_q      <= sh_d;
      perr_q    <= perr_d;
      idle_hi_q <= idle_hi_d;
    end
  end

endmodule

// File: rtl/serial_rx_fifo.sv
module serial_rx_fifo
  import serial_rx_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned PTR_W = $clog2(DEPTH),
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             deep_i,
  input  logic             push_i,
  input  logic [9:0]       push_word_i,
  input  logic             pop_i,
  output rx_word_t         head_o,
  output logic             empty_o,
  output logic [CNT_W-1:0] cnt_o
);

  rx_word_t         mem_q [DEPTH];
  logic [PTR_W-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [CNT_W-1:0] cnt_q, cnt_d, limit;
  logic             ovr_q, ovr_d;
  logic             pop_ok, store, lost;

  always_comb begin
    limit   = deep_i ? CNT_W'(DEPTH) : CNT_W'(1);
    pop_ok  = pop_i && (cnt_q != '0);
    store   = push_i && ((cnt_q < limit) || pop_ok);
    lost    = push_i && !store;
    cnt_d   = cnt_q + CNT_W'(store) - CNT_W'(pop_ok);
    wr_d    = store  ? wr_q + PTR_W'(1) : wr_q;
    rd_d    = pop_ok ? rd_q + PTR_W'(1) : rd_q;
    ovr_d   = lost ? 1'b1 : (store ? 1'b0 : ovr_q);
    empty_o = (cnt_q == '0);
    head_o  = empty_o ? '0 : mem_q[rd_q];
    cnt_o   = cnt_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
      ovr_q <= 1'b0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
      ovr_q <= ovr_d;
    end
  end

  // storage: write-enabled, no reset
  always_ff @(posedge clk_i) begin
    if (store) mem_q[wr_q] <= {ovr_q, push_word_i};
  end

endmodule

// File: rtl/serial_rx_tagq.sv
module serial_rx_tagq
  import serial_rx_pkg::*;
#(
  parameter int unsigned DIV_W = 12,
  parameter int unsigned DEPTH = 16,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] cfg_div_i,
  input  logic [1:0]       cfg_len_i,
  input  logic             cfg_par_en_i,
  input  logic             cfg_par_even_i,
  input  logic             cfg_two_stop_i,
  input  logic             cfg_fifo_en_i,
  input  logic             rxd_i,
  input  logic             rd_pop_i,
  output logic [10:0]      rd_word_o,
  output logic             rx_empty_o,
  output logic             rx_irq_o
);

  logic [1:0]       rst_pipe_q;
  logic             rst_sync_n;
  logic [1:0]       rxd_pipe_q;
  logic             tick;
  logic             frm_push;
  logic [9:0]       frm_word;
  rx_word_t         head;
  logic [CNT_W-1:0] fifo_cnt;

  // reset: asserted at once, released two edges later
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_pipe_q <= 2'b00;
    else         rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  // line synchronizer, idles high
  always_ff @(posedge clk_i or negedge rst_sync_n) begin
    if (!rst_sync_n) rxd_pipe_q <= 2'b11;
    else             rxd_pipe_q <= {rxd_pipe_q[0], rxd_i};
  end

  serial_rx_tick #(.DIV_W(DIV_W)) tick_i (
    .clk_i  (clk_i),
    .rst_ni (rst_sync_n),
    .div_i  (cfg_div_i),
    .tick_o (tick)
  );

  serial_rx_deframe frm_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_sync_n),
    .tick_i      (tick),
    .rxd_i       (rxd_pipe_q[1]),
    .len_i       (cfg_len_i),
    .par_en_i    (cfg_par_en_i),
    .par_even_i  (cfg_par_even_i),
    .two_stop_i  (cfg_two_stop_i),
    .push_o      (frm_push),
    .push_word_o (frm_word)
  );

  serial_rx_fifo #(.DEPTH(DEPTH)) q_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_sync_n),
    .deep_i      (cfg_fifo_en_i),
    .push_i      (frm_push),
    .push_word_i (frm_word),
    .pop_i       (rd_pop_i),
    .head_o      (head),
    .empty_o     (rx_empty_o),
    .cnt_o       (fifo_cnt)
  );

  assign rd_word_o = head;
  assign rx_irq_o  = ~rx_empty_o;

endmodule

// File: rtl/serial_rx_tagq_chk.sv
module serial_rx_tagq_chk #(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             rx_irq_i,
  input logic             rx_empty_i,
  input logic             pop_i,
  input logic             push_i,
  input logic [CNT_W-1:0] cnt_i,
  input logic             fifo_en_i,
  input logic             par_en_i,
  input logic [1:0]       len_i,
  input logic [10:0]      word_i
);

  // R7: interrupt mirrors queue occupancy
  p_irq_empty_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_irq_i == !rx_empty_i);

  // R7: without a push, an empty queue stays empty even when popped
  p_pop_empty_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_empty_i && !push_i) |=> rx_empty_i);

  // R5: occupancy never passes the deep limit
  p_no_overflow_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_i <= CNT_W'(DEPTH));

  // R5: single-slot mode never holds more than one character
  p_single_slot_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fifo_en_i |-> cnt_i <= CNT_W'(1));

  // R2: five-bit characters leave bits 7:5 clear
  p_upper_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rx_empty_i && len_i == 2'd0) |-> word_i[7:5] == 3'b000);

  // R3: no parity tag when parity is off
  p_no_par_tag_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rx_empty_i && !par_en_i) |-> !word_i[9]);

  // R9: empty queue reads as zero
  p_zero_when_empty_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_empty_i |-> word_i == 11'd0);

endmodule

bind serial_rx_tagq serial_rx_tagq_chk #(.DEPTH(DEPTH)) chk_i (
  .clk_i      (clk_i),
  .rst_ni     (rst_sync_n),
  .rx_irq_i   (rx_irq_o),
  .rx_empty_i (rx_empty_o),
  .pop_i      (rd_pop_i),
  .push_i     (frm_push),
  .cnt_i      (fifo_cnt),
  .fifo_en_i  (cfg_fifo_en_i),
  .par_en_i   (cfg_par_en_i),
  .len_i      (cfg_len_i),
  .word_i     (rd_word_o)
);

// File: tb/serial_rx_tagq_tb_top.sv
module serial_rx_tagq_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] div = 12'd0;
  logic [1:0]  len = 2'd3;
  logic        par_en = 1'b0;
  logic        par_even = 1'b0;
  logic        two_stop = 1'b0;
  logic        fifo_en = 1'b1;
  logic        rxd = 1'b1;
  logic        pop = 1'b0;
  logic [10:0] word;
  logic        empty;
  logic        irq;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  always #2 clk = ~clk;  // 250 MHz

  serial_rx_tagq dut_i (
    .clk_i          (clk),
    .rst_ni         (rst_n),
    .cfg_div_i      (div),
    .cfg_len_i      (len),
    .cfg_par_en_i   (par_en),
    .cfg_par_even_i (par_even),
    .cfg_two_stop_i (two_stop),
    .cfg_fifo_en_i  (fifo_en),
    .rxd_i          (rxd),
    .rd_pop_i       (pop),
    .rd_word_o      (word),
    .rx_empty_o     (empty),
    .rx_irq_o       (irq)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  function automatic logic [7:0] mask_char(input logic [7:0] d, input logic [1:0] l);
    return d & 8'((9'd1 << (5 + l)) - 9'd1);
  endfunction

  function automatic logic [10:0] exp_word(input logic [7:0] d, input logic [1:0] l,
                                           input bit pe, input bit fe, input bit ov);
    return {ov, pe, fe, mask_char(d, l)};
  endfunction

  function automatic bit par_bit(input logic [7:0] d, input logic [1:0] l, input bit even);
    return (^mask_char(d, l)) ^ !even;
  endfunction

  task automatic hold(input bit v, input int clocks);
    rxd = v;
    repeat (clocks) @(negedge clk);
  endtask

  // one frame at the configured format; optional corrupted parity / stop bits
  task automatic send(input logic [7:0] d, input bit bad_par, input bit bad_stop, input bit bad_stop2);
    int bt = 16 * (int'(div) + 1);
    hold(1'b0, bt);
    for (int i = 0; i < 5 + int'(len); i++) hold(d[i], bt);
    if (par_en) hold(par_bit(d, len, par_even) ^ bad_par, bt);
    hold(!bad_stop, bt);
    if (two_stop) hold(!bad_stop2, bt);
    hold(1'b1, 2 * bt);
  endtask

  task automatic read_check(input logic [10:0] exp, input string req);
    check(!empty, req, {31'd0, empty}, 32'd0);
    check(word == exp, req, {21'd0, word}, {21'd0, exp});
    pop = 1'b1;
    @(negedge clk);
    pop = 1'b0;
  endtask

  initial begin : watchdog
    repeat (180000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  initial begin : main
    logic [7:0] d;
    bit bp, bs;
    void'($urandom(32'h5EED_1234));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);

    // reset state
    check(empty == 1'b1, "R7 reset empty", {31'd0, empty}, 32'd1);
    check(irq == 1'b0, "R7 reset irq", {31'd0, irq}, 32'd0);
    check(word == 11'd0, "R9 reset word", {21'd0, word}, 32'd0);

    // pop on empty has no effect
    pop = 1'b1; @(negedge clk); pop = 1'b0; @(negedge clk);
    check(empty == 1'b1, "R7 pop on empty", {31'd0, empty}, 32'd1);

    // word layout, 8N1
    send(8'hA5, 0, 0, 0);
    read_check(11'h0A5, "R9 layout 8N1");

    // 5-bit character: upper bits zero
    len = 2'd0;
    send(8'hFF, 0, 0, 0);
    read_check(11'h01F, "R2 five-bit char");
    len = 2'd3;

    // false start: low for a quarter bit only
    hold(1'b0, 4);
    hold(1'b1, 48);
    check(empty == 1'b1, "R8 false start dropped", {31'd0, empty}, 32'd1);
    send(8'h3C, 0, 0, 0);
    read_check(11'h03C, "R8 frame after false start");

    // framing error, then a clean frame
    send(8'h81, 0, 1, 0);
    read_check(exp_word(8'h81, 2'd3, 0, 1, 0), "R4 framing error");
    send(8'h42, 0, 0, 0);
    read_check(11'h042, "R4 recovery after low stop");

    // two stop bits, second one low: not checked
    two_stop = 1'b1;
    send(8'h5A, 0, 0, 1);
    read_check(11'h05A, "R4 second stop unchecked");
    two_stop = 1'b0;

    // odd and even parity errors
    par_en = 1'b1; par_even = 1'b1; len = 2'd2;
    send(8'h13, 1, 0, 0);
    read_check(exp_word(8'h13, 2'd2, 1, 0, 0), "R3 even parity mismatch");
    par_even = 1'b0;
    send(8'h13, 0, 0, 0);
    read_check(exp_word(8'h13, 2'd2, 0, 0, 0), "R3 odd parity good");
    par_en = 1'b0; len = 2'd3;

    // deep queue: fill past full, check order, overrun on next stored char
    for (int i = 0; i < 17; i++) send(8'(8'h10 + i), 0, 0, 0);
    for (int i = 0; i < 16; i++) read_check(11'(8'h10 + i), "R5 deep order");
    check(empty == 1'b1, "R5 drained", {31'd0, empty}, 32'd1);
    check(irq == 1'b0, "R7 irq low when drained", {31'd0, irq}, 32'd0);
    send(8'h77, 0, 0, 0);
    read_check(exp_word(8'h77, 2'd3, 0, 0, 1), "R6 overrun on next stored");
    send(8'h78, 0, 0, 0);
    read_check(11'h078, "R6 overrun cleared");

    // single slot mode
    fifo_en = 1'b0;
    send(8'hC1, 0, 0, 0);
    check(irq == 1'b1, "R7 irq with data", {31'd0, irq}, 32'd1);
    send(8'hC2, 0, 0, 0);
    read_check(11'h0C1, "R5 single slot keeps first");
    check(empty == 1'b1, "R5 single slot held one", {31'd0, empty}, 32'd1);
    send(8'hC3, 0, 0, 0);
    read_check(exp_word(8'hC3, 2'd3, 0, 0, 1), "R6 overrun single slot");
    fifo_en = 1'b1;

    // constrained random formats, divisors and errors
    for (int it = 0; it < 40; it++) begin
      div      = 12'($urandom_range(0, 3));
      len      = 2'($urandom_range(0, 3));
      par_en   = 1'($urandom_range(0, 1));
      par_even = 1'($urandom_range(0, 1));
      two_stop = 1'($urandom_range(0, 1));
      hold(1'b1, 32 * (int'(div) + 1));
      d  = 8'($urandom);
      bp = par_en && ($urandom_range(0, 5) == 0);
      bs = ($urandom_range(0, 7) == 0);
      send(d, bp, bs, 0);
      read_check(exp_word(d, len, bp, bs, 0), "R1/R2/R3/R4 random frame");
    end

    done = 1;
    summary();
  end

endmodule